// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block gathers eight interrupt sources into a single request line and a 3-bit vector index for a small CPU core. The sources are:

- a bus-reset event;
- two taps of a free-running timer;
- three endpoint transfer-done events;
- two port-group requests, which are already masked per pin upstream.

Each source owns a sticky pending bit and an individual enable bit. A fixed priority picks the winning source, and a global enable gates the request.

Pulse-type sources set their pending bit when they are sampled high. Timer taps are counter bits, not pulses, so they set their pending bit only on a sampled 0-to-1 change. When the CPU acknowledges, the block clears the pending bit of the presented vector and drops the global enable. Firmware sets the global enable again with an explicit write. Software can overwrite the pending, enable and global-enable state through write strobes, and the state is always visible on outputs.

Top module: `vic_top`

## Requirements
- R1: While rst_ni is low and after its release, pend_o, en_o, gie_o, irq_o and vec_o are all zero.
- R2: A high sample on a pulse source sets its pending bit at that clock edge. The bit map is: bus_rst_evt_i bit 0, ep_evt_i[0..2] bits 3..5, port_sep_req_i bit 6, port_gp_req_i bit 7.
- R3: tmr_tap_i[0] maps to pending bit 1 and tmr_tap_i[1] maps to bit 2. A tap sets its bit only when it is sampled low in one cycle and high in the next. A tap held high, a falling tap, and a tap already high when reset is released set nothing.
- R4: A pending bit stays set until a pending write or an accepted acknowledge clears it.
- R5: irq_o is high exactly when gie_o is set and at least one bit of pend_o & en_o is set.
- R6: vec_o is the lowest index among the set bits of pend_o & en_o, with bit 0 highest priority. vec_o is 0 when no such bit exists.
- R7: When ack_i is sampled with irq_o high, the next cycle shows pend_o[vec_o] cleared, the other pending bits unchanged, and gie_o cleared.
- R8: When ack_i is sampled with irq_o low, it changes neither pend_o nor gie_o.
- R9: If a source's event arrives in the same cycle as the acknowledge of that source, its pending bit stays set. gie_o is still cleared.
- R10: pend_we_i, en_we_i and gie_we_i load pend_wdata_i, en_wdata_i and gie_wdata_i. Events in the same cycle as a pending write are ORed into the written value.
- R11: An accepted acknowledge and a global-enable write of 1 in the same cycle leave gie_o cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_evt_i | input | 1 | Bus-reset event pulse |
| tmr_tap_i | input | 2 | Timer counter tap bits: [0] short period, [1] long period |
| ep_evt_i | input | 3 | Endpoint transfer-done pulses |
| port_sep_req_i | input | 1 | Separate-port group request, pre-masked |
| port_gp_req_i | input | 1 | General-purpose port group request, pre-masked |
| pend_we_i | input | 1 | Pending register write strobe |
| pend_wdata_i | input | 8 | Pending write data |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable write data |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | Global enable write data |
| ack_i | input | 1 | CPU acknowledge |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 3 | Index of the presented source |
| pend_o | output | 8 | Pending bits |
| en_o | output | 8 | Enable bits |
| gie_o | output | 1 | Global enable |

## Verification
Two functions can fall in the same cycle: a new event setting a pending bit, and an acknowledge clearing that same bit. The bench drives an endpoint pulse in the very cycle it acknowledges that endpoint's vector. It judges the result by requiring the pending bit to stay set while the global enable drops. It also overlaps a pending write with an event, and an acknowledge with a global-enable write, and checks that each outcome follows the documented precedence.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_TMR  = 2;
  localparam int NUM_EP   = 3;
  localparam int NUM_PORT = 2;
  localparam int NUM_SRC  = 1 + NUM_TMR + NUM_EP + NUM_PORT;
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // bit positions, priority order (lowest index wins)
  localparam int SRC_BUS  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_EP   = SRC_TMR + NUM_TMR;
  localparam int SRC_PORT = SRC_EP + NUM_EP;
endpackage

// File: rtl/vic_rise_det.sv
module vic_rise_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // prev resets high: a tap already high at reset release needs a low first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         pend_we_i,
  input  logic [N-1:0] pend_wdata_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] pend_q, en_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic base;
    // write first, then ack clear, then events win
    assign base = pend_we_i ? pend_wdata_i[i] : pend_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        pend_q[i] <= (base & ~clr_i[i]) | evt_i[i];
        if (en_we_i) en_q[i] <= en_wdata_i[i];
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_rst_evt_i,
  input  logic [NUM_TMR-1:0]  tmr_tap_i,
  input  logic [NUM_EP-1:0]   ep_evt_i,
  input  logic                port_sep_req_i,
  input  logic                port_gp_req_i,
  input  logic                pend_we_i,
  input  logic [NUM_SRC-1:0]  pend_wdata_i,
  input  logic                en_we_i,
  input  logic [NUM_SRC-1:0]  en_wdata_i,
  input  logic                gie_we_i,
  input  logic                gie_wdata_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic [IDX_W-1:0]    vec_o,
  output logic [NUM_SRC-1:0]  pend_o,
  output logic [NUM_SRC-1:0]  en_o,
  output logic                gie_o
);
  logic [NUM_TMR-1:0]  tmr_rise;
  logic [NUM_SRC-1:0]  set_evt;
  logic [NUM_SRC-1:0]  clr_mask;
  logic [NUM_SRC-1:0]  active;
  logic                any_active;
  logic                ack_fire;
  logic                gie_q;

  vic_rise_det #(.W(NUM_TMR)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (tmr_tap_i),
    .rise_o (tmr_rise)
  );

  always_comb begin
    set_evt = '0;
    set_evt[SRC_BUS] = bus_rst_evt_i;
    set_evt[SRC_TMR +: NUM_TMR] = tmr_rise;
    set_evt[SRC_EP +: NUM_EP] = ep_evt_i;
    set_evt[SRC_PORT]     = port_sep_req_i;
    set_evt[SRC_PORT + 1] = port_gp_req_i;
  end

  assign ack_fire = ack_i & irq_o;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_mask[i] = ack_fire & (vec_o == IDX_W'(i));
  end

  vic_src_bank #(.N(NUM_SRC)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (set_evt),
    .clr_i        (clr_mask),
    .pend_we_i    (pend_we_i),
    .pend_wdata_i (pend_wdata_i),
    .en_we_i      (en_we_i),
    .en_wdata_i   (en_wdata_i),
    .pend_o       (pend_o),
    .en_o         (en_o)
  );

  assign active = pend_o & en_o;

  vic_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i (active),
    .any_o (any_active),
    .idx_o (vec_o)
  );

  // ack takes precedence over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gie_q <= 1'b0;
    else if (ack_fire) gie_q <= 1'b0;
    else if (gie_we_i) gie_q <= gie_wdata_i;
  end

  assign gie_o = gie_q;
  assign irq_o = gie_q & any_active;
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               pend_we_i,
  input logic               gie_we_i,
  input logic               irq_o,
  input logic [IDX_W-1:0]   vec_o,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [NUM_SRC-1:0] en_o,
  input logic               gie_o,
  input logic [NUM_SRC-1:0] set_evt
);
  logic [NUM_SRC-1:0] higher;
  assign higher = (NUM_SRC'(1) << vec_o) - NUM_SRC'(1);

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_o && |(pend_o & en_o)));

  assert_irq_raised_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_o && |(pend_o & en_o)) |-> irq_o);

  assert_vec_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o[vec_o] && en_o[vec_o]));

  assert_vec_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_o & en_o & higher) == '0));

  assert_ack_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !pend_we_i) |=> (!pend_o[$past(vec_o)] || $past(set_evt[vec_o])));

  assert_ack_gie_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !gie_o);

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_we_i && !(ack_i && irq_o)) |=> (($past(pend_o) & ~pend_o) == '0));

  assert_gie_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_we_i && !(ack_i && irq_o)) |=> $stable(gie_o));

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_evt != '0) |=> ((pend_o & $past(set_evt)) == $past(set_evt)));
endmodule

bind vic_top vic_top_chk #(.NUM_SRC(vic_pkg::NUM_SRC), .IDX_W(vic_pkg::IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_i     (ack_i),
  .pend_we_i (pend_we_i),
  .gie_we_i  (gie_we_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .pend_o    (pend_o),
  .en_o      (en_o),
  .gie_o     (gie_o),
  .set_evt   (set_evt)
);

// File: tb/vic_top_test.sv
module vic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {gie, pend, en, irq, vec}
  localparam logic [20:0] VECS [NVEC] = '{
    {1'b1, 8'hFF, 8'hFF, 1'b1, 3'd0},
    {1'b1, 8'hFE, 8'hFF, 1'b1, 3'd1},
    {1'b1, 8'hF0, 8'h0F, 1'b0, 3'd0},
    {1'b1, 8'h80, 8'h80, 1'b1, 3'd7},
    {1'b1, 8'h28, 8'h20, 1'b1, 3'd5},
    {1'b1, 8'h00, 8'hFF, 1'b0, 3'd0},
    {1'b1, 8'h55, 8'hAA, 1'b0, 3'd0},
    {1'b1, 8'h6C, 8'h48, 1'b1, 3'd3},
    {1'b0, 8'hFF, 8'hFF, 1'b0, 3'd0},
    {1'b1, 8'hC4, 8'hFC, 1'b1, 3'd2}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rst_evt_i = 1'b0;
  logic [1:0] tmr_tap_i = 2'b00;
  logic [2:0] ep_evt_i = 3'b000;
  logic port_sep_req_i = 1'b0, port_gp_req_i = 1'b0;
  logic pend_we_i = 1'b0, en_we_i = 1'b0, gie_we_i = 1'b0, gie_wdata_i = 1'b0;
  logic [7:0] pend_wdata_i = '0, en_wdata_i = '0;
  logic ack_i = 1'b0;
  logic irq_o, gie_o;
  logic [2:0] vec_o;
  logic [7:0] pend_o, en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vic_top uut (
    .clk_i, .rst_ni, .bus_rst_evt_i, .tmr_tap_i, .ep_evt_i,
    .port_sep_req_i, .port_gp_req_i, .pend_we_i, .pend_wdata_i,
    .en_we_i, .en_wdata_i, .gie_we_i, .gie_wdata_i, .ack_i,
    .irq_o, .vec_o, .pend_o, .en_o, .gie_o
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_all(logic [7:0] p, logic [7:0] e, logic g);
    pend_we_i = 1; pend_wdata_i = p;
    en_we_i = 1; en_wdata_i = e;
    gie_we_i = 1; gie_wdata_i = g;
    tick();
    pend_we_i = 0; en_we_i = 0; gie_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tmr_tap_i = 2'b10; // long tap high across reset release
    #(CLK_PERIOD*3);
    check("R1 pend", pend_o, 0);
    check("R1 irq/vec/gie", {irq_o, vec_o, gie_o, en_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    tick(); tick(); tick();
    check("R1 after release", {pend_o, en_o, gie_o, irq_o, vec_o}, 0);
    check("R3 high at release no event", pend_o[2], 0);

    // R3: held high, falling, then a true rise
    tick();
    check("R3 held high", pend_o, 0);
    tmr_tap_i = 2'b00; tick();
    check("R3 falling", pend_o, 0);
    tmr_tap_i = 2'b10; tick();
    check("R3 rise long tap", pend_o, 8'h04);
    tmr_tap_i = 2'b11; tick();
    tmr_tap_i = 2'b00; tick();
    check("R3 rise short tap", pend_o, 8'h06);

    // R2 pulse sources
    write_all(8'h00, 8'h00, 0);
    bus_rst_evt_i = 1; tick(); bus_rst_evt_i = 0;
    check("R2 bus reset bit0", pend_o, 8'h01);
    ep_evt_i = 3'b010; tick(); ep_evt_i = 0;
    check("R2 endpoint1 bit4", pend_o, 8'h11);
    port_sep_req_i = 1; port_gp_req_i = 1; tick();
    port_sep_req_i = 0; port_gp_req_i = 0;
    check("R2 port groups bits6,7", pend_o, 8'hD1);
    ep_evt_i = 3'b101; tick(); ep_evt_i = 0;
    check("R2 endpoints 0,2", pend_o, 8'hF9);

    // R4 sticky
    repeat (5) tick();
    check("R4 sticky", pend_o, 8'hF9);

    // R5/R6 table
    for (int i = 0; i < NVEC; i++) begin
      write_all(VECS[i][19:12], VECS[i][11:4], VECS[i][20]);
      check("R5 irq table", irq_o, VECS[i][3]);
      check("R6 vec table", vec_o, VECS[i][2:0]);
    end

    // R7 ack
    write_all(8'h18, 8'hFF, 1);
    check("R6 vec before ack", vec_o, 3);
    ack_i = 1; tick(); ack_i = 0;
    check("R7 pend after ack", pend_o, 8'h10);
    check("R7 gie after ack", {gie_o, irq_o}, 0);
    gie_we_i = 1; gie_wdata_i = 1; tick(); gie_we_i = 0;
    check("R7 next vector", {irq_o, vec_o}, {1'b1, 3'd4});

    // R8 ack ignored with irq low
    write_all(8'h18, 8'hFF, 0);
    ack_i = 1; tick(); ack_i = 0;
    check("R8 pend unchanged", pend_o, 8'h18);
    check("R8 gie unchanged", gie_o, 0);

    // R9 event on acked source
    write_all(8'h08, 8'h08, 1);
    ack_i = 1; ep_evt_i = 3'b001; tick(); ack_i = 0; ep_evt_i = 0;
    check("R9 pend kept", pend_o, 8'h08);
    check("R9 gie cleared", gie_o, 0);

    // R10 write with event
    pend_we_i = 1; pend_wdata_i = 8'h01; ep_evt_i = 3'b100; tick();
    pend_we_i = 0; ep_evt_i = 0;
    check("R10 write ORed with event", pend_o, 8'h21);
    write_all(8'h5A, 8'hA5, 1);
    check("R10 write load", {pend_o, en_o, gie_o}, {8'h5A, 8'hA5, 1'b1});

    // R11 ack vs gie write
    write_all(8'h02, 8'h02, 1);
    ack_i = 1; gie_we_i = 1; gie_wdata_i = 1; tick();
    ack_i = 0; gie_we_i = 0;
    check("R11 ack beats gie write", gie_o, 0);
    check("R11 pend cleared", pend_o, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule